// File: doc/BRIEF.md
# Codeword sync lock detector

This block sits directly below the line-code sub-layer of a forward error correction receiver. It watches a received byte stream, finds where each codeword begins by correlating against a known synchronization pattern at every bit offset, and hands the layers above a byte stream that is already aligned. It also gives a strobe on the first payload byte of each codeword. Decoding and correction happen elsewhere.

Matching tolerates bit errors. A window is accepted when its Hamming distance to the pattern is no larger than a threshold set at a port. Two acquisition schemes are chosen by a mode input. In continuous mode (downstream), a short pattern heads every codeword. A hunt, confirm and lock state machine declares lock after several good matches at the codeword spacing, and it drops lock only after a run of misses. In burst mode (upstream), a longer preamble pattern is seen once per burst. It gives lock at once and holds it for the rest of the burst. A burst-start hint re-arms the search.

Bits arrive most significant bit first within each byte. A bit offset k means that the pattern's last bit is followed by k more bits in the same byte.

Top module: `cw_sync_lock`

## Requirements
- R1: While reset is held, and after it is released with no input, `locked`, `out_valid` and `cw_start` are 0 and `bit_off` is 0.
- R2: A 40-bit window counts as a match when its Hamming distance to the active pattern is at most `max_err`. With `max_err`=3, a pattern with 3 flipped bits is accepted and one with 4 flipped bits is rejected.
- R3: While hunting, each valid byte is searched at all 8 bit offsets. When more than one offset matches, the lowest offset is taken. The chosen offset appears on `bit_off` after the clock edge that consumes the byte.
- R4: In continuous mode, `locked` rises after CONF_N consecutive matches spaced CW_BYTES bytes apart, counting the first match found by the hunt. It stays low after CONF_N-1 matches.
- R5: In continuous mode, a miss at the expected position while confirming returns the block to hunting. No `cw_start` is given until a new match is found.
- R6: In continuous mode, once locked, the block stays locked through MISS_N-1 consecutive misses. A good match clears the miss run. The MISS_N-th consecutive miss clears `locked` and resumes hunting.
- R7: In burst mode, only the burst pattern is searched for. A single match sets `locked` on the next edge, and `locked` then holds with no further checks until the next burst start.
- R8: A `burst_start` pulse in burst mode clears `locked` on the next edge and re-arms the search. In continuous mode, `burst_start` has no effect.
- R9: Each valid input byte produces one output byte one cycle later. The output byte is the 8 stream bits that end `bit_off` bits before the end of the newest input byte, most significant bit first.
- R10: `cw_start` is high with the output byte that immediately follows a pattern end, and then again every CW_BYTES valid bytes, while confirming or locked.
- R11: A cycle with `din_valid` low produces no output byte and no strobe, and it changes neither the history, the counters nor the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| burst_mode | input | 1 | 1 selects burst acquisition, 0 selects continuous |
| max_err | input | $clog2(PAT_W+1) | Largest Hamming distance that still counts as a match |
| din | input | 8 | Received byte, earliest bit in bit 7 |
| din_valid | input | 1 | `din` carries a byte this cycle |
| burst_start | input | 1 | Start-of-burst hint, re-arms burst search |
| dout | output | 8 | Codeword-aligned byte |
| out_valid | output | 1 | `dout` is valid |
| cw_start | output | 1 | `dout` is the first payload byte of a codeword |
| locked | output | 1 | Codeword lock achieved |
| bit_off | output | 3 | Bit offset currently used for alignment |

## Verification
The bench builds the block with a 24-byte codeword instead of 252, so that dozens of codewords fit in a short run. It keeps the confirm count of 4 and the miss limit of 8, and it passes both 40-bit patterns explicitly. Running the threshold at 3 puts the accept/reject edge between 3 and 4 flipped bits within reach. The short codeword brings the seven-versus-eight miss boundary, a miss while confirming, and repeated burst re-arming all within a few hundred bytes. Idle gaps inserted at random between bytes, together with a cycle-by-cycle reference model, cover alignment at offsets 0, 3 and 7.

// File: rtl/cw_sync_lock.sv
module cw_sync_lock #(
  parameter int PAT_W = 40,
  parameter int CW_BYTES = 252,
  parameter int CONF_N = 4,
  parameter int MISS_N = 8,
  parameter logic [PAT_W-1:0] CPAT = 40'hE62BD1479C,
  parameter logic [PAT_W-1:0] BPAT = 40'h5F0C93A6B1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       burst_mode,
  input  logic [$clog2(PAT_W+1)-1:0] max_err,
  input  logic [7:0]                 din,
  input  logic                       din_valid,
  input  logic                       burst_start,
  output logic [7:0]                 dout,
  output logic                       out_valid,
  output logic                       cw_start,
  output logic                       locked,
  output logic [2:0]                 bit_off
);
  localparam int HW = PAT_W + 7;
  localparam int CTR_W = $clog2(CW_BYTES);
  localparam int GW = $clog2(CONF_N + 1);
  localparam int MW = $clog2(MISS_N + 1);

  typedef enum logic [1:0] {HUNT, CONF, LOCK} st_t;

  st_t              st, st_n;
  logic [HW-9:0]    hist;
  logic [HW-1:0]    hist_n;
  logic [2:0]       off, off_n, first;
  logic [CTR_W-1:0] ctr, ctr_n;
  logic [GW-1:0]    good, good_n;
  logic [MW-1:0]    miss, miss_n;
  logic [7:0]       hit;
  logic [PAT_W-1:0] pat;
  logic             rearm, wrap, here;

  assign hist_n = {hist, din};
  assign pat    = burst_mode ? BPAT : CPAT;
  assign rearm  = burst_start && burst_mode;
  assign wrap   = (ctr == CTR_W'(CW_BYTES - 1));
  assign here   = hit[off];

  for (genvar g = 0; g < 8; g++) begin : g_corr
    assign hit[g] = $countones(hist_n[g +: PAT_W] ^ pat) <= 32'(max_err);
  end

  always_comb begin
    first = 3'd0;
    for (int i = 7; i >= 0; i--)
      if (hit[i]) first = 3'(i);
  end

  always_comb begin
    st_n = st; off_n = off; ctr_n = ctr; good_n = good; miss_n = miss;
    if (rearm) begin
      st_n = HUNT; ctr_n = '0; good_n = '0; miss_n = '0;
    end else if (din_valid) begin
      if (st == HUNT) begin
        if (|hit) begin
          off_n = first; ctr_n = '0; good_n = GW'(1);
          st_n = burst_mode ? LOCK : CONF;
        end
      end else begin
        ctr_n = wrap ? '0 : ctr + 1'b1;
        if (wrap && !burst_mode) begin
          if (st == CONF) begin
            if (here) begin
              good_n = good + 1'b1;
              if (good_n == GW'(CONF_N)) st_n = LOCK;
            end else begin
              st_n = HUNT;
            end
          end else if (here) begin
            miss_n = '0;
          end else begin
            miss_n = miss + 1'b1;
            if (miss_n == MW'(MISS_N)) begin
              st_n = HUNT; miss_n = '0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= HUNT; hist <= '0; off <= '0; ctr <= '0; good <= '0; miss <= '0;
      dout <= '0; out_valid <= 1'b0; cw_start <= 1'b0;
    end else begin
      st <= st_n; off <= off_n; ctr <= ctr_n; good <= good_n; miss <= miss_n;
      out_valid <= din_valid;
      cw_start  <= din_valid && !rearm && st != HUNT && ctr == '0;
      if (din_valid) begin
        hist <= hist_n[HW-9:0];
        dout <= hist_n[off_n +: 8];
      end
    end
  end

  assign locked  = (st == LOCK);
  assign bit_off = off;
endmodule

// File: rtl/cw_sync_lock_chk.sv
module cw_sync_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       burst_mode,
  input logic       din_valid,
  input logic       burst_start,
  input logic       out_valid,
  input logic       cw_start,
  input logic       locked,
  input logic [2:0] bit_off
);
  // R10
  strobe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cw_start |-> out_valid);

  // R11
  idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> !out_valid && !cw_start);

  // R11
  idle_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid && !burst_start |=> $stable(locked) && $stable(bit_off));

  // R8
  burst_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_mode && burst_start |=> !locked);

  // R8
  cont_hint_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_mode && burst_start && !din_valid |=> $stable(locked));

  // R7
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_mode && locked && !burst_start |=> locked);

  // R6
  drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(din_valid) || $past(burst_start));
endmodule

bind cw_sync_lock cw_sync_lock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .din_valid(din_valid),
  .burst_start(burst_start), .out_valid(out_valid), .cw_start(cw_start),
  .locked(locked), .bit_off(bit_off)
);

// File: tb/cw_sync_lock_tb.sv
module cw_sync_lock_tb;
  localparam int CLK_NS = 10;
  localparam int PW = 40;
  localparam int CW = 24;
  localparam int CONFN = 4;
  localparam int MISSN = 8;
  localparam int THR = 3;
  localparam int HWB = PW + 7;
  localparam logic [PW-1:0] CP = 40'hE62BD1479C;
  localparam logic [PW-1:0] BP = 40'h5F0C93A6B1;
  localparam logic [PW-1:0] E2 = 40'h0000100008;
  localparam logic [PW-1:0] E3 = 40'h8000010001;
  localparam logic [PW-1:0] E4 = 40'h8000110001;

  logic clk = 0, rst_n = 0, burst_mode = 0, din_valid = 0, burst_start = 0;
  logic [5:0] max_err = 6'(THR);
  logic [7:0] din = 0;
  logic [7:0] dout;
  logic out_valid, cw_start, locked;
  logic [2:0] bit_off;

  int checks = 0, failures = 0, cw_cnt = 0;
  bit gap_en = 0;
  bit txq[$];

  cw_sync_lock #(.PAT_W(PW), .CW_BYTES(CW), .CONF_N(CONFN), .MISS_N(MISSN),
                 .CPAT(CP), .BPAT(BP)) u_dut (
    .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .max_err(max_err),
    .din(din), .din_valid(din_valid), .burst_start(burst_start),
    .dout(dout), .out_valid(out_valid), .cw_start(cw_start),
    .locked(locked), .bit_off(bit_off));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int mst, moff, mctr, mgood, mmiss, hitk;
  bit mq[$];
  bit rearm_m, here_m;
  logic [PW-1:0] pm;
  logic exp_valid, exp_cw, exp_lock;
  logic [7:0] exp_dout;
  logic [2:0] exp_off;

  function automatic int mdist(int k, logic [PW-1:0] p);
    int d = 0;
    for (int i = 0; i < PW; i++)
      if (mq[HWB-k-PW+i] != p[PW-1-i]) d++;
    return d;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 0; moff = 0; mctr = 0; mgood = 0; mmiss = 0;
      mq.delete();
      for (int i = 0; i < HWB; i++) mq.push_back(1'b0);
      exp_valid = 0; exp_cw = 0; exp_lock = 0; exp_dout = 0; exp_off = 0;
    end else begin
      rearm_m = burst_start && burst_mode;
      pm = burst_mode ? BP : CP;
      exp_cw = din_valid && !rearm_m && mst != 0 && mctr == 0;
      exp_valid = din_valid;
      if (din_valid)
        for (int i = 7; i >= 0; i--) begin
          mq.push_back(din[i]);
          void'(mq.pop_front());
        end
      if (rearm_m) begin
        mst = 0; mctr = 0; mgood = 0; mmiss = 0;
      end else if (din_valid) begin
        hitk = -1;
        for (int k = 7; k >= 0; k--) if (mdist(k, pm) <= THR) hitk = k;
        here_m = mdist(moff, pm) <= THR;
        if (mst == 0) begin
          if (hitk >= 0) begin
            moff = hitk; mctr = 0; mgood = 1; mst = burst_mode ? 2 : 1;
          end
        end else if (mctr == CW - 1) begin
          mctr = 0;
          if (!burst_mode) begin
            if (mst == 1) begin
              if (here_m) begin mgood++; if (mgood == CONFN) mst = 2; end
              else mst = 0;
            end else if (here_m) mmiss = 0;
            else begin
              mmiss++;
              if (mmiss == MISSN) begin mst = 0; mmiss = 0; end
            end
          end
        end else mctr++;
      end
      if (din_valid)
        for (int i = 0; i < 8; i++) exp_dout[7-i] = mq[HWB-moff-8+i];
      exp_lock = (mst == 2);
      exp_off = 3'(moff);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(out_valid == exp_valid, "R11 out_valid", out_valid, exp_valid);
      if (exp_valid) chk(dout == exp_dout, "R9 dout", dout, exp_dout);
      chk(cw_start == exp_cw, "R10 cw_start", cw_start, exp_cw);
      chk(locked == exp_lock, burst_mode ? "R7 locked" : "R6 locked", locked, exp_lock);
      chk(bit_off == exp_off, "R3 bit_off", bit_off, exp_off);
      if (cw_start) cw_cnt++;
    end
  end

  task automatic idle();
    @(negedge clk); din_valid = 0; #1;
  endtask

  task automatic put_byte(input logic [7:0] b);
    if (gap_en && ($urandom % 4 == 0)) idle();
    @(negedge clk); din = b; din_valid = 1;
  endtask

  task automatic pump();
    logic [7:0] b;
    while (txq.size() >= 8) begin
      for (int i = 7; i >= 0; i--) b[i] = txq.pop_front();
      put_byte(b);
    end
  endtask

  task automatic send_bits(input logic [PW-1:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) txq.push_back(v[i]);
    pump();
  endtask

  task automatic send_rand(input int n);
    for (int i = 0; i < n; i++) txq.push_back(1'($urandom));
    pump();
  endtask

  task automatic align();
    while (txq.size() % 8 != 0) txq.push_back(1'b0);
    pump();
  endtask

  task automatic frame(input logic [PW-1:0] p);
    send_bits(p, PW);
    send_rand(CW * 8 - PW);
  endtask

  task automatic hint();
    @(negedge clk); din_valid = 0; burst_start = 1;
    @(negedge clk); burst_start = 0; #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(locked == 0 && out_valid == 0 && cw_start == 0 && bit_off == 0,
        "R1 reset outputs", {locked, out_valid, cw_start, bit_off}, 0);
    rst_n = 1;
    idle();
    chk(locked == 0 && out_valid == 0 && cw_start == 0 && bit_off == 0,
        "R1 after release", {locked, out_valid, cw_start, bit_off}, 0);

    // continuous acquisition at offset 3, first pattern with 3 bit errors (R2)
    send_rand(13);
    frame(CP ^ E3); frame(CP); frame(CP);
    idle();
    chk(locked == 0, "R4 three matches", locked, 0);
    frame(CP);
    idle();
    chk(locked == 1, "R4 four matches", locked, 1);
    chk(bit_off == 3, "R3 offset", bit_off, 3);

    gap_en = 1;
    repeat (7) frame(~CP);
    idle();
    chk(locked == 1, "R6 seven misses", locked, 1);
    frame(CP);
    repeat (7) frame(~CP);
    idle();
    chk(locked == 1, "R6 run cleared", locked, 1);
    frame(~CP);
    idle();
    chk(locked == 0, "R6 eighth miss", locked, 0);

    cw_cnt = 0;
    frame(CP);
    idle();
    chk(cw_cnt == 1, "R10 confirm strobe", cw_cnt, 1);
    cw_cnt = 0;
    frame(CP ^ E4);
    idle();
    chk(cw_cnt == 0, "R5 miss in confirm", cw_cnt, 0);
    chk(locked == 0, "R2 four errors", locked, 0);

    repeat (4) frame(CP);
    idle();
    chk(locked == 1, "R4 relock", locked, 1);
    cw_cnt = 0;
    frame(CP);
    idle();
    chk(cw_cnt == 1, "R10 locked strobe", cw_cnt, 1);
    hint();
    chk(locked == 1, "R8 hint ignored", locked, 1);

    // burst mode
    gap_en = 0;
    @(negedge clk); burst_mode = 1; burst_start = 1; din_valid = 0;
    @(negedge clk); burst_start = 0; #1;
    chk(locked == 0, "R8 rearm", locked, 0);
    align();
    send_rand(9); send_bits(BP ^ E2, PW); send_rand(7);
    idle();
    chk(locked == 1, "R7 immediate lock", locked, 1);
    chk(bit_off == 7, "R3 offset seven", bit_off, 7);
    gap_en = 1;
    send_rand(3 * CW * 8);
    idle();
    chk(locked == 1, "R7 held in burst", locked, 1);
    hint();
    chk(locked == 0, "R8 burst start", locked, 0);
    gap_en = 0;
    align();
    send_bits(BP ^ E4, PW); send_rand(16);
    idle();
    chk(locked == 0, "R2 burst reject", locked, 0);
    send_bits(CP, PW); send_rand(16);
    idle();
    chk(locked == 0, "R7 wrong pattern", locked, 0);
    send_bits(BP, PW);
    idle();
    chk(locked == 1, "R7 aligned preamble", locked, 1);
    chk(bit_off == 0, "R3 offset zero", bit_off, 0);

    repeat (2) idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule